// File: doc/BRIEF.md
# DMA Hardware Trigger Gate

This block sits beside a DMA channel engine and decides when the engine may go ahead with the next transfer unit. It picks one line out of a vector of hardware trigger inputs, looks for the chosen edge on that line, and turns each edge it finds into one permission to proceed. The granularity of that permission can be set. A single hit can release one block, one repeated block, one linked-list item load, or one single/burst beat.

Hits that arrive before the engine uses them are stored in a small saturating counter, so a burst of trigger edges is not lost. When the engine begins a unit of the gated kind while the grant is high, it uses up one stored hit. The grant then stays low until the engine reports that the unit has finished. If a hit arrives while the counter is already full, a sticky overrun flag records it. Any change to the selected line or to the edge polarity throws away the edge history, so the reconfiguration itself cannot look like an edge.

Top module: `dma_trig_gate`

## Requirements
- R1: After synchronous reset, `pending` is 0 and both `grant` and `overrun` are low.
- R2: With `trig_pol` = 1 (rising), a 0-to-1 change on the selected input, applied before clock edge n, raises `pending` by one at edge n+1 and not before.
- R3: With `trig_pol` = 2 (falling), a 1-to-0 change on the selected input raises `pending` by one.
- R4: With `trig_pol` = 0 (off) or 3 (reserved), no edge of any input changes `pending`.
- R5: Only the input indexed by `trig_sel` is observed. A `trig_sel` value above 58 behaves as off, and edges on unselected inputs have no effect.
- R6: A change to `trig_sel` or `trig_pol` produces no hit, even when the old and new selected levels differ. Edges that come after the history has refilled (two clocks) are counted.
- R7: `grant` is high exactly when `pending` is nonzero and no gated unit is in flight.
- R8: The unit kinds are encoded on `unit_kind` as 0 block, 1 repeated block, 2 linked-list item load, 3 single/burst. A `unit_start` whose kind equals `gate_mode` while `grant` is high lowers `pending` by one and holds `grant` low until `unit_done`.
- R9: A `unit_start` whose kind differs from `gate_mode` leaves `pending` and `grant` unchanged.
- R10: `pending` saturates at 2^CNT_W-1. A hit that arrives while it is full sets `overrun`, which stays high until reset.
- R11: A hit and a gated start in the same cycle leave `pending` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | NUM_TRIG | Hardware trigger lines, already synchronous to clk |
| trig_sel | input | SEL_W | Index of the observed trigger line |
| trig_pol | input | 2 | Edge select: 0 off, 1 rising, 2 falling, 3 off |
| gate_mode | input | 2 | Unit kind that a hit releases (same encoding as unit_kind) |
| unit_start | input | 1 | Engine begins a unit this cycle |
| unit_kind | input | 2 | Kind of the unit being started |
| unit_done | input | 1 | Engine finished the gated unit in flight |
| grant | output | 1 | Engine may start a unit of the gated kind |
| pending | output | CNT_W | Stored, unused trigger hits |
| overrun | output | 1 | Sticky: a hit was dropped because the counter was full |

## Verification
The properties assume that the engine starts a gated unit only while `grant` is high. They also assume that `unit_done` refers only to a unit that the gate released. The step and overrun checks rely on at most one hit per cycle, which is true because hits come from a single selected line. The stimulus changes every input on the falling clock edge. It raises `unit_start` for the gated kind only after it has seen `grant` high, and it pulses `unit_done` once per gated start. It holds each trigger level for at least two clocks, so every edge the bench intends to produce is visible to the detector.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

    typedef enum logic [1:0] {
        POL_OFF  = 2'd0,
        POL_RISE = 2'd1,
        POL_FALL = 2'd2,
        POL_RSVD = 2'd3
    } trig_pol_e;

    typedef enum logic [1:0] {
        UNIT_BLOCK     = 2'd0,
        UNIT_RPT_BLOCK = 2'd1,
        UNIT_LINK_LOAD = 2'd2,
        UNIT_BEAT      = 2'd3
    } unit_kind_e;

    // Edge decode of two consecutive samples under a polarity setting.
    function automatic logic edge_hit(trig_pol_e pol, logic cur, logic prev);
        case (pol)
            POL_RISE: edge_hit = cur & ~prev;
            POL_FALL: edge_hit = ~cur & prev;
            default:  edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect
    import dma_trig_pkg::*;
#(
    parameter int NUM_TRIG = 64,
    parameter int MAX_SEL  = 58,
    parameter int SEL_W    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]    sel,
    input  trig_pol_e           pol,
    output logic                hit
);
    localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(MAX_SEL);

    logic [SEL_W-1:0] sel_q;
    trig_pol_e        pol_q;
    logic             cur_s, prev_s;
    logic             fill_one, fill_two;
    logic             cfg_chg, sel_ok, sampled;

    assign cfg_chg = (sel != sel_q) || (pol != pol_q);
    assign sel_ok  = ({1'b0, sel} <= SEL_LIMIT);
    assign sampled = sel_ok ? trig_in[sel] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            pol_q    <= POL_OFF;
            cur_s    <= 1'b0;
            prev_s   <= 1'b0;
            fill_one <= 1'b0;
            fill_two <= 1'b0;
        end else begin
            sel_q    <= sel;
            pol_q    <= pol;
            cur_s    <= sampled;
            prev_s   <= cur_s;
            // history is trusted only after two samples under one setting
            fill_one <= !cfg_chg;
            fill_two <= fill_one && !cfg_chg;
        end
    end

    // pol_q matches the setting under which cur_s and prev_s were taken
    assign hit = fill_two && edge_hit(pol_q, cur_s, prev_s);

endmodule

// File: rtl/trig_pend_ctr.sv
module trig_pend_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             take,
    input  logic             unit_done,
    output logic [CNT_W-1:0] pending,
    output logic             grant,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             in_flight;
    logic             full;
    logic [CNT_W-1:0] pend_nx;

    assign full = (pending == CNT_MAX);

    always_comb begin
        pend_nx = pending;
        case ({hit, take})
            2'b10:   if (!full) pend_nx = pending + CNT_W'(1);
            2'b01:   pend_nx = pending - CNT_W'(1);
            default: pend_nx = pending;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= '0;
            overrun   <= 1'b0;
            in_flight <= 1'b0;
        end else begin
            pending <= pend_nx;
            if (hit && !take && full) overrun <= 1'b1;
            if (take)           in_flight <= 1'b1;
            else if (unit_done) in_flight <= 1'b0;
        end
    end

    assign grant = (pending != '0) && !in_flight;

endmodule

// File: rtl/dma_trig_gate.sv
module dma_trig_gate
    import dma_trig_pkg::*;
#(
    parameter int  NUM_TRIG = 64,
    parameter int  MAX_SEL  = 58,
    parameter int  CNT_W    = 3,
    localparam int SEL_W    = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]    trig_sel,
    input  logic [1:0]          trig_pol,
    input  logic [1:0]          gate_mode,
    input  logic                unit_start,
    input  logic [1:0]          unit_kind,
    input  logic                unit_done,
    output logic                grant,
    output logic [CNT_W-1:0]    pending,
    output logic                overrun
);
    logic evt_hit;
    logic evt_take;

    trig_edge_detect #(
        .NUM_TRIG(NUM_TRIG),
        .MAX_SEL (MAX_SEL),
        .SEL_W   (SEL_W)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .trig_in(trig_in),
        .sel    (trig_sel),
        .pol    (trig_pol_e'(trig_pol)),
        .hit    (evt_hit)
    );

    // only a start of the gated kind consumes a stored hit
    assign evt_take = unit_start && (unit_kind_e'(unit_kind) == unit_kind_e'(gate_mode)) && grant;

    trig_pend_ctr #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .hit      (evt_hit),
        .take     (evt_take),
        .unit_done(unit_done),
        .pending  (pending),
        .grant    (grant),
        .overrun  (overrun)
    );

endmodule

// File: rtl/dma_trig_gate_chk.sv
module dma_trig_gate_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       trig_pol,
    input logic [1:0]       gate_mode,
    input logic             unit_start,
    input logic [1:0]       unit_kind,
    input logic             grant,
    input logic [CNT_W-1:0] pending,
    input logic             overrun,
    input logic             evt_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic gated_go;
    assign gated_go = unit_start && (unit_kind == gate_mode) && grant;

    assert_grant_pending_R7: assert property (@(posedge clk) disable iff (rst)
        grant |-> (pending != '0));

    assert_take_closes_R8: assert property (@(posedge clk) disable iff (rst)
        gated_go |=> !grant);

    assert_take_no_rise_R8: assert property (@(posedge clk) disable iff (rst)
        gated_go |=> (pending <= $past(pending)));

    assert_masked_off_R4: assert property (@(posedge clk) disable iff (rst)
        (trig_pol == 2'd0) |=> (pending <= $past(pending)));

    assert_foreign_unit_R9: assert property (@(posedge clk) disable iff (rst)
        (unit_start && (unit_kind != gate_mode) && !evt_hit) |=> (pending == $past(pending)));

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        ((pending == CNT_MAX) && !gated_go) |=> (pending == CNT_MAX));

    assert_single_step_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pending == $past(pending)) ||
                  (pending == $past(pending) + CNT_W'(1)) ||
                  (pending == $past(pending) - CNT_W'(1))));

endmodule

bind dma_trig_gate dma_trig_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_pol  (trig_pol),
    .gate_mode (gate_mode),
    .unit_start(unit_start),
    .unit_kind (unit_kind),
    .grant     (grant),
    .pending   (pending),
    .overrun   (overrun),
    .evt_hit   (evt_hit)
);

// File: tb/dma_trig_gate_tb.sv
`timescale 1ns/1ps
module dma_trig_gate_tb;
    localparam int NUM_TRIG = 64;
    localparam int CNT_W    = 3;
    localparam int SEL_W    = 6;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NUM_TRIG-1:0] trig_in = '0;
    logic [SEL_W-1:0]    trig_sel = '0;
    logic [1:0]          trig_pol = 2'd0;
    logic [1:0]          gate_mode = 2'd0;
    logic                unit_start = 1'b0;
    logic [1:0]          unit_kind = 2'd0;
    logic                unit_done = 1'b0;
    logic                grant;
    logic [CNT_W-1:0]    pending;
    logic                overrun;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_trig_gate #(.NUM_TRIG(NUM_TRIG), .MAX_SEL(58), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .trig_in(trig_in), .trig_sel(trig_sel),
        .trig_pol(trig_pol), .gate_mode(gate_mode), .unit_start(unit_start),
        .unit_kind(unit_kind), .unit_done(unit_done), .grant(grant),
        .pending(pending), .overrun(overrun)
    );

    typedef struct packed {
        logic [5:0] line;
        logic [5:0] sel;
        logic [1:0] pol;
        logic [3:0] delta;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t TBL [NVEC] = '{
        '{6'd5,  6'd5,  2'd1, 4'd1},
        '{6'd5,  6'd5,  2'd2, 4'd1},
        '{6'd5,  6'd5,  2'd0, 4'd0},
        '{6'd5,  6'd5,  2'd3, 4'd0},
        '{6'd9,  6'd5,  2'd1, 4'd0},
        '{6'd58, 6'd58, 2'd1, 4'd1},
        '{6'd59, 6'd59, 2'd1, 4'd0},
        '{6'd0,  6'd0,  2'd2, 4'd1},
        '{6'd63, 6'd63, 2'd2, 4'd0}
    };

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string row_req(vec_t v);
        if (v.sel > 6'd58 || v.line != v.sel) return "R5";
        if (v.pol == 2'd0 || v.pol == 2'd3)   return "R4";
        if (v.pol == 2'd1)                    return "R2";
        return "R3";
    endfunction

    task automatic drain();
        for (int k = 0; k < 20 && grant; k++) begin
            unit_start = 1'b1; unit_kind = gate_mode;
            tick();
            unit_start = 1'b0; unit_done = 1'b1;
            tick();
            unit_done = 1'b0;
            tick();
        end
    endtask

    task automatic pulse(int idx, int hold);
        trig_in[idx] = 1'b1; tick(hold);
        trig_in[idx] = 1'b0; tick(hold);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        // R1: reset state
        check(pending == 0 && !grant && !overrun, "R1 reset state", int'(pending), 0);

        // Vector table: one pulse per row, pending measured against expected delta
        gate_mode = 2'd3;
        for (int i = 0; i < NVEC; i++) begin
            trig_sel = TBL[i].sel;
            trig_pol = TBL[i].pol;
            tick(4);
            pulse(int'(TBL[i].line), 3);
            check(pending == CNT_W'(TBL[i].delta), row_req(TBL[i]), int'(pending), int'(TBL[i].delta));
            drain();
        end

        // R6: selection change between lines at different levels
        trig_sel = 6'd3; trig_pol = 2'd1;
        trig_in[3] = 1'b0; trig_in[4] = 1'b1;
        tick(4);
        trig_sel = 6'd4;
        tick(5);
        check(pending == 0, "R6 no hit from selection change", int'(pending), 0);
        trig_in[4] = 1'b0; tick(3);
        trig_in[4] = 1'b1; tick(3);
        check(pending == 1, "R6 edge after refill counted", int'(pending), 1);
        trig_in[4] = 1'b0;
        drain();

        // R2 timing: rising edge seen at pending two edges after the input change
        gate_mode = 2'd0;
        trig_sel = 6'd7; trig_pol = 2'd1;
        tick(4);
        trig_in[7] = 1'b1;
        tick();
        check(pending == 0, "R2 no count one edge after change", int'(pending), 0);
        tick();
        check(pending == 1, "R2 count two edges after change", int'(pending), 1);
        check(grant == 1'b1, "R7 grant with pending", int'(grant), 1);
        trig_in[7] = 1'b0; tick(2);
        trig_in[7] = 1'b1; tick(3);
        trig_in[7] = 1'b0; tick(2);
        check(pending == 2, "R2 second hit stored", int'(pending), 2);

        // R8: gated start consumes and closes the grant
        unit_start = 1'b1; unit_kind = 2'd0;
        tick();
        unit_start = 1'b0;
        check(pending == 1, "R8 start consumes hit", int'(pending), 1);
        check(grant == 1'b0, "R8 grant low while in flight", int'(grant), 0);
        // R9: foreign kind while busy
        unit_start = 1'b1; unit_kind = 2'd2;
        tick();
        unit_start = 1'b0;
        tick();
        check(pending == 1, "R9 foreign start ignored while busy", int'(pending), 1);
        unit_done = 1'b1;
        tick();
        unit_done = 1'b0;
        check(grant == 1'b1, "R7 grant reopens after done", int'(grant), 1);
        // R9: foreign kind with grant high
        unit_start = 1'b1; unit_kind = 2'd1;
        tick();
        unit_start = 1'b0;
        tick();
        check(pending == 1 && grant, "R9 foreign start leaves count", int'(pending), 1);

        // R11: hit and gated start in the same cycle
        trig_in[7] = 1'b1;
        tick();
        unit_start = 1'b1; unit_kind = 2'd0;
        tick();
        unit_start = 1'b0;
        check(pending == 1, "R11 hit and take cancel", int'(pending), 1);
        check(grant == 1'b0, "R8 in flight after take", int'(grant), 0);
        unit_done = 1'b1; tick(); unit_done = 1'b0;
        trig_in[7] = 1'b0; tick(2);
        drain();
        check(pending == 0 && !grant, "R7 drained grant low", int'(pending), 0);

        // R10: saturation and overrun
        for (int p = 0; p < 7; p++) pulse(7, 2);
        check(pending == 7 && !overrun, "R10 full without overrun", int'(pending), 7);
        pulse(7, 2);
        check(pending == 7, "R10 saturated count", int'(pending), 7);
        check(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
        tick(3);
        check(overrun == 1'b1, "R10 overrun sticky", int'(overrun), 1);

        // R1: reset clears everything
        rst = 1'b1; tick(2); rst = 1'b0; tick();
        check(pending == 0 && !grant && !overrun, "R1 reset after overrun", int'(pending), 0);

        finish_run();
    end

endmodule